// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block decides conditional branches while they sit in the decode stage of a five-stage in-order pipeline. It tests one register against zero, or two registers against each other, and adds the sign-extended word offset to the sequential address with its own adder. From those two results it chooses the next fetch address. It also decides whether the instruction now being fetched must be squashed into a bubble, and whether fetch must pause for one cycle. Resolving in stage 2 rather than stage 4 reduces the cost of a redirect from three cycles to one.

A two-bit policy input selects how control hazards are handled, and it may change at run time. The four policies are: always pay the slot, guess not-taken, guess taken, or treat the following instruction as a delay slot that always executes. Under the guess-taken policy the target is only known in decode, so fetch is pointed at the target before the outcome is used. A branch that turns out not taken therefore needs a registered correction in the following cycle.

If the branch's source register is being written by the instruction currently in execute, the block raises a fetch hold for that cycle and leaves the branch unresolved. The comparison then sees the new value once the writer has moved on.

Top module: `branch_early_resolve`

## Requirements
- R1: After reset, with no branch in decode, next_pc_o equals if_pc_i + 4 and both flush_ifid_o and hold_fetch_o are 0.
- R2: The condition code id_cond_i selects the test: 0 means rs value equals zero, 1 means rs value is non-zero, 2 means rs value equals rt value, and 3 means rs value differs from rt value.
- R3: The branch target is id_pc_i + 4 + (sign-extended id_imm_i multiplied by 4), with wrap-around at 32 bits.
- R4: A valid branch whose rs index, or whose rt index when id_cond_i is 2 or 3, matches a nonzero ex_wr_idx_i while ex_wr_en_i is 1 gives hold_fetch_o=1, flush_ifid_o=0 and next_pc_o=if_pc_i. A write to register 0 never causes a hold.
- R5: With policy 0 (always pay), a resolved branch gives flush_ifid_o=1, and next_pc_o is the target when taken or id_pc_i+4 when not taken.
- R6: With policy 1 (guess not-taken), a taken branch gives next_pc_o=target and flush_ifid_o=1. A not-taken branch gives next_pc_o=if_pc_i+4 and flush_ifid_o=0.
- R7: With policy 2 (guess taken), a resolved branch gives next_pc_o=target and flush_ifid_o=1. If that branch was not taken, the next cycle gives next_pc_o equal to that branch's id_pc_i+4 and flush_ifid_o=1. If it was taken, no correction follows.
- R8: With policy 3 (delay slot), flush_ifid_o stays 0, and next_pc_o is the target when taken or if_pc_i+4 when not taken.
- R9: During a correction cycle, the contents of decode and the execute write port are ignored, and no second correction is armed.
- R10: When decode holds no valid branch and no correction is pending, next_pc_o equals if_pc_i + 4 with no flush and no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | Hazard policy: 0 pay, 1 guess not-taken, 2 guess taken, 3 delay slot |
| if_pc_i | input | 32 | Address of the instruction in fetch |
| id_valid_i | input | 1 | Decode stage holds a valid instruction |
| id_is_branch_i | input | 1 | Decode instruction is a conditional branch |
| id_cond_i | input | 2 | Condition code of the branch |
| id_pc_i | input | 32 | Address of the branch in decode |
| id_imm_i | input | 16 | Signed word offset |
| id_rs_idx_i | input | 5 | First source register index |
| id_rt_idx_i | input | 5 | Second source register index |
| id_rs_val_i | input | 32 | First source register value |
| id_rt_val_i | input | 32 | Second source register value |
| ex_wr_en_i | input | 1 | Execute-stage instruction writes a register |
| ex_wr_idx_i | input | 5 | Register written by the execute-stage instruction |
| next_pc_o | output | 32 | Address to fetch next |
| flush_ifid_o | output | 1 | Turn the fetch/decode register into a bubble |
| hold_fetch_o | output | 1 | Keep fetch and decode for one cycle |

## Verification
Every output except the guess-taken correction is combinational in the same cycle as its decode inputs. The bench therefore drives inputs just after a falling edge and samples one time unit later, within the same cycle. The correction that follows a not-taken branch under policy 2 is due exactly one rising edge later. The bench keeps its own one-entry record of that pending correction, updated on each rising edge, and compares the following cycle against it. Random policies, conditions and hazards are mixed with directed cases for every condition code, extreme offsets, register-0 writes and a branch presented during a correction.

// File: rtl/bres_pkg.sv
package bres_pkg;

  typedef enum logic [1:0] {
    POL_PAY     = 2'd0,
    POL_GUESS_N = 2'd1,
    POL_GUESS_T = 2'd2,
    POL_SLOT    = 2'd3
  } policy_e;

  typedef enum logic [1:0] {
    CC_RS_ZERO  = 2'd0,
    CC_RS_NZERO = 2'd1,
    CC_RS_EQ_RT = 2'd2,
    CC_RS_NE_RT = 2'd3
  } cond_e;

  // two-operand codes read the second register
  function automatic logic cond_reads_rt(input cond_e c);
    return (c == CC_RS_EQ_RT) || (c == CC_RS_NE_RT);
  endfunction

endpackage

// File: rtl/brz_cond.sv
module brz_cond
  import bres_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cond_e            cond_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  output logic             taken_o
);

  function automatic logic eval_cond(input cond_e c, input logic [XLEN-1:0] a,
                                     input logic [XLEN-1:0] b);
    logic is_zero, is_same;
    is_zero = (a == '0);
    is_same = (a == b);
    unique case (c)
      CC_RS_ZERO:  return is_zero;
      CC_RS_NZERO: return !is_zero;
      CC_RS_EQ_RT: return is_same;
      default:     return !is_same;
    endcase
  endfunction

  assign taken_o = eval_cond(cond_i, a_i, b_i);

endmodule

// File: rtl/brz_target.sv
module brz_target #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  target_o
);

  localparam int EXT_W = XLEN - IMM_W - 2;
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

  function automatic logic [XLEN-1:0] word_offset(input logic [IMM_W-1:0] imm);
    return {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
  endfunction

  assign seq_o    = pc_i + WORD_BYTES;
  assign target_o = seq_o + word_offset(imm_i);

endmodule

// File: rtl/brz_hazard.sv
module brz_hazard
  import bres_pkg::*;
#(
  parameter int RIDX_W   = 5,
  parameter bit ZERO_REG = 1'b1
) (
  input  logic              br_req_i,
  input  cond_e             cond_i,
  input  logic [RIDX_W-1:0] rs_idx_i,
  input  logic [RIDX_W-1:0] rt_idx_i,
  input  logic              ex_wr_en_i,
  input  logic [RIDX_W-1:0] ex_wr_idx_i,
  output logic              hold_req_o
);

  logic wr_live;
  logic hit_rs, hit_rt;

  generate
    if (ZERO_REG) begin : g_zero_hard
      assign wr_live = ex_wr_en_i && (ex_wr_idx_i != '0);
    end else begin : g_zero_soft
      assign wr_live = ex_wr_en_i;
    end
  endgenerate

  assign hit_rs     = (ex_wr_idx_i == rs_idx_i);
  assign hit_rt     = cond_reads_rt(cond_i) && (ex_wr_idx_i == rt_idx_i);
  assign hold_req_o = br_req_i && wr_live && (hit_rs || hit_rt);

endmodule

// File: rtl/brz_ctrl.sv
module brz_ctrl
  import bres_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  policy_e         policy_i,
  input  logic            br_req_i,
  input  logic            hold_req_i,
  input  logic            taken_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] id_seq_i,
  input  logic [XLEN-1:0] if_seq_i,
  input  logic [XLEN-1:0] if_pc_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            flush_o,
  output logic            hold_o,
  output logic            fix_pending_o
);

  logic            fix_q;
  logic [XLEN-1:0] fix_pc_q;
  logic            arm_fix;
  logic            resolve_ev;

  assign resolve_ev    = br_req_i && !hold_req_i && !fix_q;
  assign fix_pending_o = fix_q;

  always_comb begin
    next_pc_o = if_seq_i;
    flush_o   = 1'b0;
    hold_o    = 1'b0;
    arm_fix   = 1'b0;
    if (fix_q) begin
      next_pc_o = fix_pc_q;
      flush_o   = 1'b1;
    end else if (br_req_i && hold_req_i) begin
      hold_o    = 1'b1;
      next_pc_o = if_pc_i;
    end else if (br_req_i) begin
      unique case (policy_i)
        POL_PAY: begin
          flush_o   = 1'b1;
          next_pc_o = taken_i ? target_i : id_seq_i;
        end
        POL_GUESS_N: begin
          if (taken_i) begin
            flush_o   = 1'b1;
            next_pc_o = target_i;
          end
        end
        POL_GUESS_T: begin
          flush_o   = 1'b1;
          next_pc_o = target_i;
          arm_fix   = !taken_i;
        end
        default: begin
          next_pc_o = taken_i ? target_i : if_seq_i;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fix_q    <= 1'b0;
      fix_pc_q <= '0;
    end else begin
      fix_q <= arm_fix;
      if (arm_fix) fix_pc_q <= id_seq_i;
    end
  end

  p_hold_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> !flush_o);

  p_fix_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fix_q |=> !fix_q);

  p_fix_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fix_q |-> $past(resolve_ev && policy_i == POL_GUESS_T && !taken_i));

  p_slot_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_i == POL_SLOT && !fix_q) |-> !flush_o);

  p_taken_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_ev && taken_i && policy_i != POL_SLOT) |-> (next_pc_o == target_i && flush_o));

endmodule

// File: rtl/branch_early_resolve.sv
module branch_early_resolve
  import bres_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        policy_i,
  input  logic [XLEN-1:0]   if_pc_i,
  input  logic              id_valid_i,
  input  logic              id_is_branch_i,
  input  logic [1:0]        id_cond_i,
  input  logic [XLEN-1:0]   id_pc_i,
  input  logic [IMM_W-1:0]  id_imm_i,
  input  logic [RIDX_W-1:0] id_rs_idx_i,
  input  logic [RIDX_W-1:0] id_rt_idx_i,
  input  logic [XLEN-1:0]   id_rs_val_i,
  input  logic [XLEN-1:0]   id_rt_val_i,
  input  logic              ex_wr_en_i,
  input  logic [RIDX_W-1:0] ex_wr_idx_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              flush_ifid_o,
  output logic              hold_fetch_o
);

  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

  cond_e           cond;
  policy_e         policy;
  logic            br_req;
  logic            hold_req;
  logic            taken;
  logic [XLEN-1:0] id_seq, target, if_seq;
  logic            fix_pending;

  assign cond   = cond_e'(id_cond_i);
  assign policy = policy_e'(policy_i);
  assign br_req = id_valid_i && id_is_branch_i;
  assign if_seq = if_pc_i + WORD_BYTES;

  brz_cond #(.XLEN(XLEN)) u_cond (
    .cond_i (cond),
    .a_i    (id_rs_val_i),
    .b_i    (id_rt_val_i),
    .taken_o(taken)
  );

  brz_target #(.XLEN(XLEN), .IMM_W(IMM_W)) u_target (
    .pc_i    (id_pc_i),
    .imm_i   (id_imm_i),
    .seq_o   (id_seq),
    .target_o(target)
  );

  brz_hazard #(.RIDX_W(RIDX_W), .ZERO_REG(1'b1)) u_hazard (
    .br_req_i   (br_req),
    .cond_i     (cond),
    .rs_idx_i   (id_rs_idx_i),
    .rt_idx_i   (id_rt_idx_i),
    .ex_wr_en_i (ex_wr_en_i),
    .ex_wr_idx_i(ex_wr_idx_i),
    .hold_req_o (hold_req)
  );

  brz_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .policy_i     (policy),
    .br_req_i     (br_req),
    .hold_req_i   (hold_req),
    .taken_i      (taken),
    .target_i     (target),
    .id_seq_i     (id_seq),
    .if_seq_i     (if_seq),
    .if_pc_i      (if_pc_i),
    .next_pc_o    (next_pc_o),
    .flush_o      (flush_ifid_o),
    .hold_o       (hold_fetch_o),
    .fix_pending_o(fix_pending)
  );

  p_idle_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_req && !fix_pending) |-> (next_pc_o == if_pc_i + WORD_BYTES
                                   && !flush_ifid_o && !hold_fetch_o));

  p_reg0_nohold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_wr_idx_i == '0) |-> !hold_fetch_o);

endmodule

// File: tb/test_branch_early_resolve.sv
module test_branch_early_resolve;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  policy;
  logic [31:0] if_pc, id_pc, rs_val, rt_val;
  logic        id_valid, id_br, ex_we;
  logic [1:0]  cond;
  logic [15:0] imm;
  logic [4:0]  rs_idx, rt_idx, ex_idx;
  logic [31:0] next_pc;
  logic        flush, hold;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench record of a pending guess-taken correction
  bit          m_fix = 1'b0;
  logic [31:0] m_fix_pc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_early_resolve i_branch_early_resolve (
    .clk(clk), .rst_n(rst_n), .policy_i(policy), .if_pc_i(if_pc),
    .id_valid_i(id_valid), .id_is_branch_i(id_br), .id_cond_i(cond),
    .id_pc_i(id_pc), .id_imm_i(imm), .id_rs_idx_i(rs_idx), .id_rt_idx_i(rt_idx),
    .id_rs_val_i(rs_val), .id_rt_val_i(rt_val), .ex_wr_en_i(ex_we),
    .ex_wr_idx_i(ex_idx), .next_pc_o(next_pc), .flush_ifid_o(flush),
    .hold_fetch_o(hold)
  );

  function automatic bit b_taken(input logic [1:0] c, input logic [31:0] a,
                                 input logic [31:0] b);
    if (c == 2'd0) return a == 0;
    if (c == 2'd1) return a != 0;
    if (c == 2'd2) return a == b;
    return a != b;
  endfunction

  function automatic logic [31:0] b_target(input logic [31:0] pc, input logic [15:0] off);
    int s;
    s = int'($signed(off));
    return pc + 32'd4 + 32'(s * 4);
  endfunction

  function automatic bit b_hazard();
    if (!(id_valid && id_br) || !ex_we || ex_idx == 0) return 0;
    return (ex_idx == rs_idx) || (cond >= 2 && ex_idx == rt_idx);
  endfunction

  task automatic idle_inputs();
    id_valid = 0; id_br = 0; cond = 0; id_pc = 0; imm = 0;
    rs_idx = 0; rt_idx = 0; rs_val = 0; rt_val = 0; ex_we = 0; ex_idx = 0;
  endtask

  // drives already applied; compute expectation, compare, advance model
  task automatic check_now(input string tag);
    logic [31:0] e_pc; bit e_fl, e_ho, arm, tk;
    string t;
    arm = 0; e_fl = 0; e_ho = 0; e_pc = if_pc + 32'd4;
    tk = b_taken(cond, rs_val, rt_val);
    t = tag;
    if (m_fix) begin
      e_pc = m_fix_pc; e_fl = 1; if (t == "") t = "R9";
    end else if (!(id_valid && id_br)) begin
      if (t == "") t = "R10";
    end else if (b_hazard()) begin
      e_ho = 1; e_pc = if_pc; if (t == "") t = "R4";
    end else begin
      case (policy)
        2'd0: begin e_fl = 1; e_pc = tk ? b_target(id_pc, imm) : id_pc + 32'd4; if (t == "") t = "R5"; end
        2'd1: begin if (tk) begin e_fl = 1; e_pc = b_target(id_pc, imm); end if (t == "") t = "R6"; end
        2'd2: begin e_fl = 1; e_pc = b_target(id_pc, imm); arm = !tk; if (t == "") t = "R7"; end
        default: begin e_pc = tk ? b_target(id_pc, imm) : if_pc + 32'd4; if (t == "") t = "R8"; end
      endcase
    end
    checks++;
    if (next_pc !== e_pc || flush !== e_fl || hold !== e_ho) begin
      errors++;
      $display("FAIL %s: got pc=%h flush=%b hold=%b, expected pc=%h flush=%b hold=%b",
               t, next_pc, flush, hold, e_pc, e_fl, e_ho);
    end
    @(posedge clk);
    m_fix = arm;
    if (arm) m_fix_pc = id_pc + 32'd4;
  endtask

  task automatic branch(input logic [1:0] pol, input logic [1:0] c, input logic [31:0] pc,
                        input logic [15:0] off, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    idle_inputs();
    policy = pol; id_valid = 1; id_br = 1; cond = c; id_pc = pc; imm = off;
    rs_idx = 5'd3; rt_idx = 5'd4; rs_val = a; rt_val = b; if_pc = pc + 32'd4;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; policy = 0; if_pc = 32'h100; idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1 check_now("R1");

    // R2: every condition code, slot policy exposes the decision at next_pc
    branch(2'd3, 2'd0, 32'h1000, 16'd8, 32'd0, 32'd5); #1 check_now("R2");
    branch(2'd3, 2'd0, 32'h1000, 16'd8, 32'd7, 32'd5); #1 check_now("R2");
    branch(2'd3, 2'd1, 32'h1000, 16'd8, 32'd7, 32'd5); #1 check_now("R2");
    branch(2'd3, 2'd1, 32'h1000, 16'd8, 32'd0, 32'd5); #1 check_now("R2");
    branch(2'd3, 2'd2, 32'h1000, 16'd8, 32'd9, 32'd9); #1 check_now("R2");
    branch(2'd3, 2'd2, 32'h1000, 16'd8, 32'd9, 32'd8); #1 check_now("R2");
    branch(2'd3, 2'd3, 32'h1000, 16'd8, 32'd9, 32'd8); #1 check_now("R2");
    branch(2'd3, 2'd3, 32'h1000, 16'd8, 32'd9, 32'd9); #1 check_now("R2");

    // R3: extreme offsets and wrap
    branch(2'd1, 2'd0, 32'h0002_0000, 16'h8000, 32'd0, 32'd0); #1 check_now("R3");
    branch(2'd1, 2'd0, 32'h0000_1000, 16'h7FFF, 32'd0, 32'd0); #1 check_now("R3");
    branch(2'd1, 2'd0, 32'h0000_0000, 16'hFFFF, 32'd0, 32'd0); #1 check_now("R3");

    // R4: hazards on rs, on rt only for two-operand codes, none for reg 0
    branch(2'd1, 2'd0, 32'h2000, 16'd4, 32'd0, 32'd0); ex_we = 1; ex_idx = 5'd3; #1 check_now("R4");
    branch(2'd1, 2'd2, 32'h2000, 16'd4, 32'd0, 32'd0); ex_we = 1; ex_idx = 5'd4; #1 check_now("R4");
    branch(2'd1, 2'd0, 32'h2000, 16'd4, 32'd0, 32'd0); ex_we = 1; ex_idx = 5'd4; #1 check_now("R4");
    branch(2'd1, 2'd0, 32'h2000, 16'd4, 32'd0, 32'd0); rs_idx = 0; ex_we = 1; ex_idx = 0; #1 check_now("R4");

    // R5, R6 both outcomes
    branch(2'd0, 2'd0, 32'h3000, 16'd12, 32'd0, 32'd0); #1 check_now("R5");
    branch(2'd0, 2'd0, 32'h3000, 16'd12, 32'd1, 32'd0); #1 check_now("R5");
    branch(2'd1, 2'd1, 32'h3000, 16'd12, 32'd1, 32'd0); #1 check_now("R6");
    branch(2'd1, 2'd1, 32'h3000, 16'd12, 32'd0, 32'd0); #1 check_now("R6");

    // R7 not-taken then correction; R9 branch and hazard offered during it
    branch(2'd2, 2'd0, 32'h4000, 16'd20, 32'd1, 32'd0); #1 check_now("R7");
    branch(2'd2, 2'd0, 32'h5000, 16'd20, 32'd1, 32'd0); ex_we = 1; ex_idx = 5'd3;
    if_pc = 32'h4054; #1 check_now("R9");
    @(negedge clk); idle_inputs(); if_pc = 32'h4004; #1 check_now("R7");
    branch(2'd2, 2'd0, 32'h4100, 16'd20, 32'd0, 32'd0); #1 check_now("R7");
    @(negedge clk); idle_inputs(); if_pc = 32'h4154; #1 check_now("R7");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      idle_inputs();
      policy = 2'($urandom_range(0, 3));
      if_pc  = {$urandom_range(0, 32'h3FFF_FFFF), 2'b00};
      if ($urandom_range(0, 9) < 6) begin
        id_valid = 1; id_br = 1;
      end else begin
        id_valid = 1'($urandom_range(0, 1)); id_br = 1'($urandom_range(0, 1));
      end
      cond   = 2'($urandom_range(0, 3));
      id_pc  = {$urandom_range(0, 32'h3FFF_FFFF), 2'b00};
      imm    = 16'($urandom);
      rs_idx = 5'($urandom_range(0, 7));
      rt_idx = 5'($urandom_range(0, 7));
      rs_val = ($urandom_range(0, 2) == 0) ? 32'd0 : $urandom;
      rt_val = ($urandom_range(0, 2) == 0) ? rs_val : $urandom;
      ex_we  = ($urandom_range(0, 3) == 0);
      ex_idx = 5'($urandom_range(0, 7));
      #1 check_now("");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial void'($urandom(32'h5eed_1234));

endmodule